// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This block compares two IEEE-754 operands of one format, chosen by the exponent and fraction width parameters (single precision by default, double by setting 11 and 52). From each accepted operand pair it produces, in the same cycle, an 8-bit condition code, a full-width predicate mask for one of eight compare predicates picked by a 3-bit opcode, the minimum and the maximum of the pair, and two invalid-operation flags. One flag belongs to the predicate and one to the min/max pair.

Operands are captured when `in_valid` is high. All results are taken from that captured pair and appear one cycle later, qualified by `out_valid`. NaN detection covers quiet and signaling NaNs. Positive and negative zero compare equal. Signaling NaNs matter only for the invalid flags.

Top module: `fp_cmp_unit`

## Requirements
- R1: `cc` is 0x00 when a > b, 0x01 when a < b and 0x40 when a == b. Ordering uses the sign first, then exponent and fraction read as one unsigned magnitude (the larger magnitude is smaller for negative operands).
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), `cc` is 0x45.
- R3: `pred_op` encodes 0 eq, 1 neq, 2 le, 3 nle, 4 lt, 5 nlt, 6 unordered, 7 ordered. Each odd code is the exact inverse of the even code below it, so neq, nle and nlt are true when an operand is NaN.
- R4: `pred_mask` is all ones when the predicate holds and all zeros otherwise, across the full operand width.
- R5: `min_res` is a when a < b, else b. `max_res` is a when b < a, else b.
- R6: -0 and +0 compare equal: `cc` is 0x40, eq is true, and min and max both return the second operand.
- R7: When either operand is NaN, `min_res` and `max_res` both equal the second operand.
- R8: `pred_invalid` is set for le, nle, lt and nlt when either operand is any NaN. For eq, neq, unordered and ordered it is set only when either operand is a signaling NaN (NaN with the top fraction bit 0).
- R9: `minmax_invalid` is set when either operand is any NaN.
- R10: `out_valid` is low after reset and rises exactly one cycle after `in_valid`. While `in_valid` is low, the captured pair and every result hold their values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures operands and opcode |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| pred_op | input | 3 | Predicate select |
| out_valid | output | 1 | Results valid |
| cc | output | 8 | Condition code |
| pred_mask | output | W | Predicate result mask |
| min_res | output | W | Minimum |
| max_res | output | W | Maximum |
| pred_invalid | output | 1 | Invalid flag of the predicate |
| minmax_invalid | output | 1 | Invalid flag of min/max |

## Verification
The predicate and the min/max selection both act on every accepted pair, and each raises its own invalid flag in the same result cycle. The bench provokes disagreement between the two with NaN operands under quiet predicates. For example, a quiet NaN under eq must leave `pred_invalid` low while `minmax_invalid` is high and both min and max return the second operand. A signaling NaN under eq must set both flags. Every vector is judged on all six result fields in that one cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [2:0] {
    PR_EQ = 3'd0, PR_NE = 3'd1, PR_LE = 3'd2, PR_NLE = 3'd3,
    PR_LT = 3'd4, PR_NLT = 3'd5, PR_UN = 3'd6, PR_ORD = 3'd7
  } pred_e;

  localparam logic [7:0] CC_GT = 8'h00;
  localparam logic [7:0] CC_LT = 8'h01;
  localparam logic [7:0] CC_EQ = 8'h40;
  localparam logic [7:0] CC_UN = 8'h45;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } opnd_cls_t;

  typedef struct packed {
    logic un;
    logic eq;
    logic lt;
    logic gt;
  } rel_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int W     = MAG_W + 1
) (
  input  logic [W-1:0]     val,
  output opnd_cls_t        cls,
  output logic [MAG_W-1:0] mag,
  output logic             sign
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    sign     = val[W-1];
    mag      = val[MAG_W-1:0];
    exp_f    = val[MAG_W-1:FRAC_W];
    frac_f   = val[FRAC_W-1:0];
    cls.nan  = (&exp_f) && (|frac_f);
    cls.snan = cls.nan && !frac_f[FRAC_W-1];
    cls.zero = (mag == '0);
  end
endmodule

// File: rtl/fp_order.sv
module fp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  input  opnd_cls_t        a_cls,
  input  opnd_cls_t        b_cls,
  output rel_t             rel
);
  logic mag_lt, mag_gt, same;

  always_comb begin
    mag_lt = (a_mag < b_mag);
    mag_gt = (a_mag > b_mag);
    same   = (a_sign == b_sign) && (a_mag == b_mag);
    rel.un = a_cls.nan || b_cls.nan;
    rel.eq = !rel.un && (same || (a_cls.zero && b_cls.zero));
    if (rel.un || rel.eq)
      rel.lt = 1'b0;
    else if (a_sign != b_sign)
      rel.lt = a_sign;
    else
      rel.lt = a_sign ? mag_gt : mag_lt;
    rel.gt = !rel.un && !rel.eq && !rel.lt;
  end

  // R1
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot({rel.un, rel.eq, rel.lt, rel.gt}));
endmodule

// File: rtl/fp_result.sv
module fp_result
  import fpcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  rel_t         rel,
  input  opnd_cls_t    a_cls,
  input  opnd_cls_t    b_cls,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [7:0]   cc,
  output logic [W-1:0] mask,
  output logic [W-1:0] mn,
  output logic [W-1:0] mx,
  output logic         pinv,
  output logic         mminv
);
  logic base, hit, any_nan, any_snan, signal_kind;

  always_comb begin
    any_nan  = a_cls.nan || b_cls.nan;
    any_snan = a_cls.snan || b_cls.snan;
    unique case (1'b1)
      rel.un:  cc = CC_UN;
      rel.eq:  cc = CC_EQ;
      rel.lt:  cc = CC_LT;
      default: cc = CC_GT;
    endcase
    case (op[2:1])
      2'd0:    base = rel.eq;
      2'd1:    base = rel.lt || rel.eq;
      2'd2:    base = rel.lt;
      default: base = rel.un;
    endcase
    hit         = base ^ op[0];
    mask        = {W{hit}};
    signal_kind = (op[2:1] == 2'd1) || (op[2:1] == 2'd2);
    pinv        = signal_kind ? any_nan : any_snan;
    mminv       = any_nan;
    mn          = rel.lt ? a : b;
    mx          = rel.gt ? a : b;
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int W     = MAG_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   pred_op,
  output logic         out_valid,
  output logic [7:0]   cc,
  output logic [W-1:0] pred_mask,
  output logic [W-1:0] min_res,
  output logic [W-1:0] max_res,
  output logic         pred_invalid,
  output logic         minmax_invalid
);
  logic [W-1:0] a_q, b_q, a_d, b_d;
  logic [2:0]   op_q, op_d;
  logic         vld_q, vld_d;

  always_comb begin
    a_d   = in_valid ? op_a : a_q;
    b_d   = in_valid ? op_b : b_q;
    op_d  = in_valid ? pred_op : op_q;
    vld_d = in_valid;
  end

  always_ff @(posedge clk) begin
    a_q  <= a_d;
    b_q  <= b_d;
    op_q <= op_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  logic [1:0][W-1:0]     opnd;
  opnd_cls_t [1:0]       cls;
  logic [1:0][MAG_W-1:0] mag;
  logic [1:0]            sgn;
  rel_t                  rel;

  assign opnd[0] = a_q;
  assign opnd[1] = b_q;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val(opnd[i]), .cls(cls[i]), .mag(mag[i]), .sign(sgn[i])
    );
  end

  fp_order #(.MAG_W(MAG_W)) u_order (
    .clk(clk), .rst_n(rst_n), .chk_en(vld_q),
    .a_sign(sgn[0]), .b_sign(sgn[1]), .a_mag(mag[0]), .b_mag(mag[1]),
    .a_cls(cls[0]), .b_cls(cls[1]), .rel(rel)
  );

  fp_result #(.W(W)) u_res (
    .rel(rel), .a_cls(cls[0]), .b_cls(cls[1]), .op(op_q), .a(a_q), .b(b_q),
    .cc(cc), .mask(pred_mask), .mn(min_res), .mx(max_res),
    .pinv(pred_invalid), .mminv(minmax_invalid)
  );

  assign out_valid = vld_q;

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R4
  mask_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pred_mask == '0 || pred_mask == '1));
  // R5
  min_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (min_res == a_q || min_res == b_q));
  // R7
  nan_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && minmax_invalid) |-> (cc == CC_UN && min_res == b_q && max_res == b_q));
  // R6
  min_a_only_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && min_res != b_q) |-> (cc == CC_LT));
endmodule

// File: tb/fp_cmp_unit_tb.sv
module fp_cmp_unit_tb;
  localparam int W = 32;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [7:0]  cc;
    logic        m;
    logic        mina;
    logic        maxa;
    logic        pinv;
    logic        mminv;
  } vec_t;

  localparam int NV = 21;
  // a, b, op, cc, mask, min-is-a, max-is-a, pred_invalid, minmax_invalid
  localparam vec_t VECS [NV] = '{
    '{32'h40000000, 32'h3F800000, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 gt eq
    '{32'h3F800000, 32'h40000000, 3'd4, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 lt
    '{32'h3F800000, 32'h3F800000, 3'd2, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 equal le
    '{32'hBF800000, 32'hC0000000, 3'd4, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 negatives
    '{32'hC0000000, 32'h3F800000, 3'd5, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 nlt
    '{32'h80000000, 32'h00000000, 3'd0, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 -0,+0
    '{32'h00000000, 32'h80000000, 3'd3, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 +0,-0 nle
    '{32'h7FC00000, 32'h3F800000, 3'd0, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 R8 qnan eq
    '{32'h3F800000, 32'h7FC00000, 3'd1, 8'h45, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 neq nan
    '{32'h7FC00000, 32'h3F800000, 3'd4, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 lt qnan
    '{32'h3F800000, 32'h7F800001, 3'd0, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 snan eq
    '{32'h7F800001, 32'h7F800001, 3'd6, 8'h45, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 snan uod
    '{32'h7FC00000, 32'h40000000, 3'd7, 8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 qnan od
    '{32'h3F800000, 32'h40000000, 3'd6, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 uod
    '{32'h3F800000, 32'h40000000, 3'd7, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 od
    '{32'h7F800000, 32'h40000000, 3'd3, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 inf nle
    '{32'h00000001, 32'h00000000, 3'd4, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 denorm
    '{32'hC0000000, 32'hBF800000, 3'd2, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 neg le
    '{32'h7FC00000, 32'h3F800000, 3'd2, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 le nan
    '{32'h7FC00000, 32'h3F800000, 3'd3, 8'h45, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 nle nan
    '{32'h40000000, 32'h3F800000, 3'd1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}  // R3 neq
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] op_a, op_b;
  logic [2:0]   pred_op;
  logic         out_valid, pred_invalid, minmax_invalid;
  logic [7:0]   cc;
  logic [W-1:0] pred_mask, min_res, max_res;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fp_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred_op(pred_op), .out_valid(out_valid), .cc(cc), .pred_mask(pred_mask),
    .min_res(min_res), .max_res(max_res), .pred_invalid(pred_invalid),
    .minmax_invalid(minmax_invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(negedge clk);
    op_a = a; op_b = b; pred_op = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; pred_op = '0;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].op);
      check("R10 out_valid", {63'd0, out_valid}, 64'd1);
      check("R1,R2 cc", {56'd0, cc}, {56'd0, VECS[i].cc});
      check("R3,R4 pred_mask", {32'd0, pred_mask}, {32'd0, {32{VECS[i].m}}});
      check("R5,R6,R7 min_res", {32'd0, min_res},
            {32'd0, VECS[i].mina ? VECS[i].a : VECS[i].b});
      check("R5,R6,R7 max_res", {32'd0, max_res},
            {32'd0, VECS[i].maxa ? VECS[i].a : VECS[i].b});
      check("R8 pred_invalid", {63'd0, pred_invalid}, {63'd0, VECS[i].pinv});
      check("R9 minmax_invalid", {63'd0, minmax_invalid}, {63'd0, VECS[i].mminv});
    end

    // R10: hold while in_valid is low, inputs toggled
    apply(32'h3F800000, 32'h40000000, 3'd4);
    @(negedge clk);
    op_a = 32'h7FC00000; op_b = 32'h80000000; pred_op = 3'd7;
    @(negedge clk);
    check("R10 out_valid low", {63'd0, out_valid}, 64'd0);
    check("R10 cc held", {56'd0, cc}, 64'h01);
    check("R10 mask held", {32'd0, pred_mask}, 64'hFFFFFFFF);
    check("R10 min held", {32'd0, min_res}, 64'h3F800000);
    check("R10 minmax_invalid held", {63'd0, minmax_invalid}, 64'd0);

    // R10: back-to-back pairs, each result one cycle after its strobe
    @(negedge clk);
    op_a = 32'h40000000; op_b = 32'h3F800000; pred_op = 3'd0; in_valid = 1'b1;
    @(negedge clk);
    check("R10 first of pair cc", {56'd0, cc}, 64'h00);
    op_a = 32'h80000000; op_b = 32'h00000000; pred_op = 3'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 second of pair cc", {56'd0, cc}, 64'h40);
    check("R6 second of pair max", {32'd0, max_res}, 64'h00000000);
    check("R10 out_valid stays", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R10 out_valid drops", {63'd0, out_valid}, 64'd0);

    finish_run();
  end
endmodule